// File: doc/BRIEF.md
# Cycle-Skip Controller with Light-Load Power-Down

The block makes the on/off decision for a switching converter that regulates by skipping whole cycles. A one-clock tick marks the start of each switching cycle. On that tick the block samples the feedback-enable input: a high lets the cycle fire and a low skips it. The decision is registered and held on `fire_en` until the next tick, so the input may change freely between ticks.

The block also watches the sequence of fired and skipped cycles for a very light load of roughly 0.6 % of full load. The signature it looks for is a run of `RUN_LEN` skipped cycles, then exactly one fired cycle, then a second run of `RUN_LEN` skipped cycles. When that run completes, the block enters power-down and stops all switching.

Power-down has two steps. The first step waits for the supply-low wake input. The second step waits for the supply-recharged input. After recharge the block returns to normal evaluation with the detector cleared. The load is then judged again from the start with the same pattern, so the block either sleeps again or keeps regulating.

Top module: `cyc_skip_ctrl`

## Requirements
- R1: `cyc_start` is the only event that samples `fb_en`. `fire_en` takes the sampled value on the clock edge after the tick and holds it until the next tick, whatever `fb_en` does between ticks.
- R2: In normal mode, a tick with `fb_en`=1 sets `fire_en`=1 (the cycle fires). A tick with `fb_en`=0 sets `fire_en`=0 (the cycle is skipped).
- R3: Power-down is entered after this sequence of ticks: `RUN_LEN` consecutive skips, exactly one fire, then `RUN_LEN` consecutive skips. `pwr_down` rises on the clock edge after the tick that completes the second run.
- R4: A first skip run longer than `RUN_LEN` still arms the detector. After such a run, one fire followed by `RUN_LEN` skips enters power-down.
- R5: If a second fire arrives after the single fire and before the second run completes, the detector restarts from zero. A first run shorter than `RUN_LEN` that is broken by a fire also restarts the count.
- R6: While `pwr_down`=1, `fire_en` is 0. Ticks, `fb_en` and `recharged` have no effect until `wake_low` is asserted.
- R7: `wake_low` during the sleep step moves the block to the recharge step, and `pwr_down` stays 1. `recharged` in the recharge step clears `pwr_down` on the next edge. A tick in that same cycle is ignored.
- R8: After recharge the detector starts from zero. A complete new pattern is needed before power-down is entered again.
- R9: While `rst_n`=0, and after it is released, `fire_en`=0, `pwr_down`=0, and every counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock tick at the start of a switching cycle |
| fb_en | input | 1 | Feedback enable, sampled on the tick |
| wake_low | input | 1 | Supply has discharged to its wake level |
| recharged | input | 1 | Supply is back at its regulation level |
| fire_en | output | 1 | Switch enable for the current cycle |
| pwr_down | output | 1 | Power-down in progress (sleep or recharge step) |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the tick that completes the second skip run and the entry into power-down. The bench drives that completing tick and checks that `pwr_down` rises on the same edge on which `fire_en` settles at 0.

The second pair is `recharged` and a tick with `fb_en`=1. The bench drives them in the same clock and expects `pwr_down` to clear while `fire_en` stays 0, because that tick must be ignored. A behavioural reference model follows every clock, so each of these collisions is compared against its expected outcome.

// File: rtl/cyc_skip_pkg.sv
package cyc_skip_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_REFILL = 2'd2
  } cs_mode_t;

  typedef enum logic [1:0] {
    PH_SEEK  = 2'd0,
    PH_ARMED = 2'd1,
    PH_GAP   = 2'd2
  } cs_phase_t;
endpackage

// File: rtl/cs_fire_gate.sv
module cs_fire_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic fb_en,
  output logic fire_en
);
  always_ff @(posedge clk) begin
    if (!rst_n)      fire_en <= 1'b0;
    else if (!active) fire_en <= 1'b0;
    else if (tick)   fire_en <= fb_en;
  end

  // R1: without a tick the switch enable never moves
  assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(fire_en));
endmodule

// File: rtl/cs_light_load_det.sv
module cs_light_load_det #(
  parameter int RUN_LEN = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic fired,
  output logic hit
);
  import cyc_skip_pkg::*;
  localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  cs_phase_t        phase;
  logic [CNT_W-1:0] cnt;
  logic             run_done;

  assign run_done = (cnt == LAST);
  assign hit      = tick && !fired && (phase == PH_GAP) && run_done;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase <= PH_SEEK;
      cnt   <= '0;
    end else if (tick) begin
      if (fired) begin
        cnt <= '0;
        case (phase)
          PH_ARMED: phase <= PH_GAP;
          default:  phase <= PH_SEEK;
        endcase
      end else begin
        case (phase)
          PH_SEEK: begin
            if (run_done) begin
              phase <= PH_ARMED;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_GAP: begin
            if (run_done) begin
              phase <= PH_SEEK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  // R5: a second fire inside the gap throws the pattern away
  assert_refire_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fired && !clr && phase == PH_GAP) |=> (phase == PH_SEEK && cnt == '0));
  // R4: an armed detector stays armed through further skips
  assert_armed_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fired && !clr && phase == PH_ARMED) |=> (phase == PH_ARMED));
endmodule

// File: rtl/cs_mode_fsm.sv
module cs_mode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic wake_low,
  input  logic recharged,
  output logic active,
  output logic pwr_down
);
  import cyc_skip_pkg::*;
  cs_mode_t mode;

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= MODE_RUN;
    else begin
      case (mode)
        MODE_RUN:    if (hit)       mode <= MODE_SLEEP;
        MODE_SLEEP:  if (wake_low)  mode <= MODE_REFILL;
        MODE_REFILL: if (recharged) mode <= MODE_RUN;
        default:                    mode <= MODE_RUN;
      endcase
    end
  end

  assign active   = (mode == MODE_RUN);
  assign pwr_down = !active;

  // R7: power-down only ends after a recharge indication
  assert_exit_on_recharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> $past(recharged));
  // R6: the sleep step ignores everything but wake
  assert_sleep_waits_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_SLEEP && !$past(wake_low)) |-> (mode == MODE_SLEEP));
endmodule

// File: rtl/cyc_skip_ctrl.sv
module cyc_skip_ctrl #(
  parameter int RUN_LEN = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic fb_en,
  input  logic wake_low,
  input  logic recharged,
  output logic fire_en,
  output logic pwr_down
);
  logic active;
  logic hit;

  cs_mode_fsm u_mode (
    .clk(clk), .rst_n(rst_n), .hit(hit), .wake_low(wake_low),
    .recharged(recharged), .active(active), .pwr_down(pwr_down)
  );

  cs_light_load_det #(.RUN_LEN(RUN_LEN)) u_det (
    .clk(clk), .rst_n(rst_n), .clr(!active), .tick(cyc_start && active),
    .fired(fb_en), .hit(hit)
  );

  cs_fire_gate u_gate (
    .clk(clk), .rst_n(rst_n), .active(active), .tick(cyc_start),
    .fb_en(fb_en), .fire_en(fire_en)
  );

  // R6: no switching while powered down
  assert_no_fire_in_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !fire_en);
  // R3: entry happens only on a skipped cycle tick
  assert_entry_on_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(cyc_start && !fb_en));
  // R9: reset leaves the block in normal mode with the switch off
  assert_reset_state_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> (!pwr_down && !fire_en));
endmodule

// File: tb/sim_cyc_skip_ctrl.sv
module sim_cyc_skip_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, fb_en = 1'b0, wake_low = 1'b0, recharged = 1'b0;
  logic fire_en, pwr_down;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur = "R9";

  // reference model state
  int m_mode = 0;   // 0 normal, 1 sleeping, 2 refilling
  int m_fire = 0;
  int m_hist[$];    // outcomes since the detector last restarted

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_skip_ctrl #(.RUN_LEN(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .fb_en(fb_en),
    .wake_low(wake_low), .recharged(recharged),
    .fire_en(fire_en), .pwr_down(pwr_down)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Returns 1 when the history ends with >=N skips, one fire, N skips.
  function automatic bit pattern_seen();
    int sz = m_hist.size();
    int first_run = 0;
    if (sz < 2*N + 1) return 1'b0;
    for (int i = 0; i < N; i++) if (m_hist[sz-1-i] != 0) return 1'b0;
    if (m_hist[sz-1-N] != 1) return 1'b0;
    for (int i = sz-2-N; i >= 0; i--) begin
      if (m_hist[i] != 0) break;
      first_run++;
    end
    return first_run >= N;
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      m_mode = 0; m_fire = 0; m_hist.delete();
    end else if (m_mode == 0) begin
      if (cyc_start) begin
        m_fire = fb_en;
        m_hist.push_back(int'(fb_en));
        if (pattern_seen()) begin
          m_mode = 1; m_fire = 0; m_hist.delete();
        end
      end
    end else if (m_mode == 1) begin
      m_fire = 0;
      if (wake_low) m_mode = 2;
    end else begin
      m_fire = 0;
      if (recharged) m_mode = 0;
    end
  endtask

  task automatic cyc(input bit t, input bit f, input bit w, input bit r);
    cyc_start = t; fb_en = f; wake_low = w; recharged = r;
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc_start = 1'b0; wake_low = 1'b0; recharged = 1'b0;
    check(fire_en == m_fire[0], {cur, " fire_en"}, int'(fire_en), m_fire);
    check(pwr_down == (m_mode != 0), {cur, " pwr_down"}, int'(pwr_down), int'(m_mode != 0));
  endtask

  task automatic tick(input bit f);
    cyc(1'b1, f, 1'b0, 1'b0);
    cyc(1'b0, ~f, 1'b0, 1'b0);  // fb_en moves between ticks: must be ignored
  endtask

  task automatic skips(input int k);
    for (int i = 0; i < k; i++) tick(1'b0);
  endtask

  initial begin
    repeat (3) cyc(1'b1, 1'b1, 1'b0, 1'b0);  // inputs busy during reset
    check(fire_en == 1'b0 && pwr_down == 1'b0, "R9 reset state", int'({fire_en, pwr_down}), 0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);

    cur = "R2";
    tick(1'b1);
    check(fire_en == 1'b1, "R2 fired cycle", int'(fire_en), 1);
    cur = "R1";
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check(fire_en == 1'b1, "R1 held between ticks", int'(fire_en), 1);
    tick(1'b0);
    check(fire_en == 1'b0, "R2 skipped cycle", int'(fire_en), 0);

    cur = "R3";
    skips(N); tick(1'b1); skips(N-1);
    check(pwr_down == 1'b0, "R3 one skip short", int'(pwr_down), 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check(pwr_down == 1'b1 && fire_en == 1'b0, "R3 entry on completing tick", int'(pwr_down), 1);

    cur = "R6";
    cyc(1'b1, 1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    check(pwr_down == 1'b1 && fire_en == 1'b0, "R6 sleep ignores tick and recharge", int'(fire_en), 0);

    cur = "R7";
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    check(pwr_down == 1'b1, "R7 still down while refilling", int'(pwr_down), 1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1);
    check(pwr_down == 1'b0 && fire_en == 1'b0, "R7 exit, same-cycle tick ignored", int'(fire_en), 0);

    cur = "R8";
    skips(N-1); tick(1'b1); skips(N);
    check(pwr_down == 1'b0, "R8 short first run after wake", int'(pwr_down), 0);
    tick(1'b1); skips(N);
    check(pwr_down == 1'b1, "R8 fresh pattern re-enters", int'(pwr_down), 1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);

    cur = "R5";
    skips(N); tick(1'b1); skips(1); tick(1'b1); skips(N);
    check(pwr_down == 1'b0, "R5 second fire restarts", int'(pwr_down), 0);
    tick(1'b1); skips(N);
    check(pwr_down == 1'b1, "R5 clean pattern after restart", int'(pwr_down), 1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);

    cur = "R4";
    skips(2*N+3); tick(1'b1); skips(N);
    check(pwr_down == 1'b1, "R4 long first run arms", int'(pwr_down), 1);

    cur = "R1";
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    check(fire_en == 1'b0, "R1 no tick no fire", int'(fire_en), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule